// File: doc/BRIEF.md
# Zero-Order-Hold Sample-Rate Converter to 44.1 kHz

This block turns a stereo sample stream arriving at any rate between 8 kHz and 48 kHz into a stereo stream at exactly 44.1 kHz. The whole block runs from one clock of 16.9344 MHz, which is 384 times 44.1 kHz. Incoming left/right pairs enter through a valid/ready port and wait in a small first-in first-out buffer.

A timebase derives an enable at 320 × 44.1 kHz (14.112 MHz) from a fractional accumulator. This is the upsampled grid. A controller holds the current sample for N of these ticks and then takes the next one from the buffer. N is written into a register and equals 320 × 44100 / f_in: 294 for 48 kHz, 320 for 44.1 kHz, 441 for 32 kHz and 1764 for 8 kHz. Decimating by 320 back to 44.1 kHz is done by presenting the held pair with a one-cycle strobe every 384 clocks.

The controller has two states. PRIME is entered at reset and waits for the buffer to become non-empty. The transition PRIME→HOLD takes the first pair. HOLD counts ticks. It has a self-transition on every tick, and on every N-th tick it either takes the next pair or, when the buffer is empty, keeps the old one.

Top module: `hold_src44`

## Requirements
- R1: `out_strobe` is high for exactly one clock, and consecutive strobes are exactly 384 clocks apart.
- R2: Every 384-clock output period contains exactly 320 ticks of the upsampled grid. With N = 320, each strobe therefore presents the pair that follows the one shown at the previous strobe, one to one.
- R3: The held pair advances once every N ticks. Over K strobes the presented index advances by K·320/N, within one. For N = 640 the advance per strobe is 0 or 1 and sums to 5 over 10 strobes.
- R4: `out_left` and `out_right` change only on the clock in which `out_strobe` is high. The two always come from the same input pair.
- R5: The buffer holds `DEPTH` pairs and `in_ready` is low exactly when it is full. Accepted pairs are presented in arrival order, and none is lost while the buffer is neither overrun nor empty.
- R6: A pair offered with `in_valid` high while `in_ready` is low is dropped and never presented. `overflow_flag` rises one clock later and stays high until reset.
- R7: When a new pair is due and the buffer is empty, the last pair keeps being presented. `underflow_flag` rises one clock later and stays high until reset.
- R8: The hold factor register loads `n_wr_data` on a clock with `n_wr` high. Its reset value is 294 (a 48 kHz input). A value of 0 acts as 1, so a pair is consumed on every tick and the presented index advances by 320 per strobe.
- R9: While reset is held and immediately after it, `out_strobe`, both flags and both output words are 0 and `in_ready` is 1.
- R10: While no pair has yet arrived after reset (state PRIME), the block does not raise `underflow_flag` and presents zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16.9344 MHz system clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pair offered |
| in_ready | output | 1 | Buffer can accept a pair |
| in_left | input | DATA_W | Left input sample |
| in_right | input | DATA_W | Right input sample |
| n_wr | input | 1 | Write enable for the hold factor |
| n_wr_data | input | N_W | New hold factor N |
| out_strobe | output | 1 | One-clock pulse at 44.1 kHz |
| out_left | output | DATA_W | Presented left sample |
| out_right | output | DATA_W | Presented right sample |
| underflow_flag | output | 1 | Sticky: a due pair was missing |
| overflow_flag | output | 1 | Sticky: an offered pair was dropped |

## Verification
The strobe and the new output pair are registered together, so the data belonging to a strobe is read in the same clock as that strobe. Both flags are registered one clock after the offending edge, and the bench reads them at least one falling edge after the stimulus. A pair pushed into the buffer reaches the outputs only at a later strobe, up to N ticks plus the buffer drain time after the push. For this reason every rate check waits a few strobes after an N change or a feed change before it measures. The bench compares index advances across whole strobe windows rather than individual cycles, and all outputs are sampled on falling edges.

// File: rtl/hold_src44_pkg.sv
package hold_src44_pkg;
    typedef enum logic [0:0] {
        ST_PRIME = 1'b0,
        ST_HOLD  = 1'b1
    } ctrl_state_t;

    localparam int unsigned DEFAULT_N = 294;
endpackage

// File: rtl/hold_src44_fifo.sv
module hold_src44_fifo #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign rdata = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push && !full) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push && !full)
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop && !empty)
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            unique case ({push && !full, pop && !empty})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/hold_src44_timebase.sv
module hold_src44_timebase #(
    parameter int unsigned UP_M    = 320,
    parameter int unsigned OUT_DIV = 384
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick,
    output logic strobe_pre
);
    localparam int unsigned AW = $clog2(OUT_DIV) + 2;
    localparam int unsigned DW = $clog2(OUT_DIV);

    logic [AW-1:0] acc;
    logic [AW-1:0] acc_sum;
    logic [DW-1:0] div_cnt;

    assign acc_sum    = acc + AW'(UP_M);
    assign tick       = (acc_sum >= AW'(OUT_DIV));
    assign strobe_pre = (div_cnt == DW'(OUT_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc     <= '0;
            div_cnt <= '0;
        end else begin
            acc     <= tick ? acc_sum - AW'(OUT_DIV) : acc_sum;
            div_cnt <= strobe_pre ? '0 : div_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hold_src44_ctrl.sv
module hold_src44_ctrl
    import hold_src44_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned N_W    = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [N_W-1:0]    n_val,
    input  logic              buf_empty,
    input  logic [DATA_W-1:0] buf_left,
    input  logic [DATA_W-1:0] buf_right,
    output logic              pop,
    output logic              uflow_pulse,
    output logic [DATA_W-1:0] held_left,
    output logic [DATA_W-1:0] held_right
);
    ctrl_state_t    state, state_nx;
    logic [N_W-1:0] hold_cnt;
    logic [N_W-1:0] n_eff;
    logic           load, cnt_clr, cnt_inc;

    assign n_eff = (n_val == '0) ? N_W'(1) : n_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PRIME;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx    = state;
        pop         = 1'b0;
        uflow_pulse = 1'b0;
        load        = 1'b0;
        cnt_clr     = 1'b0;
        cnt_inc     = 1'b0;
        unique case (state)
            ST_PRIME: begin
                if (!buf_empty) begin
                    pop      = 1'b1;
                    load     = 1'b1;
                    cnt_clr  = 1'b1;
                    state_nx = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (tick) begin
                    if (hold_cnt >= n_eff - 1'b1) begin
                        cnt_clr = 1'b1;
                        if (!buf_empty) begin
                            pop  = 1'b1;
                            load = 1'b1;
                        end else begin
                            uflow_pulse = 1'b1;
                        end
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            default: state_nx = ST_PRIME;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_cnt   <= '0;
            held_left  <= '0;
            held_right <= '0;
        end else begin
            if (cnt_clr)      hold_cnt <= '0;
            else if (cnt_inc) hold_cnt <= hold_cnt + 1'b1;
            if (load) begin
                held_left  <= buf_left;
                held_right <= buf_right;
            end
        end
    end
endmodule

// File: rtl/hold_src44.sv
module hold_src44
    import hold_src44_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned N_W     = 11,
    parameter int unsigned DEPTH   = 8,
    parameter int unsigned UP_M    = 320,
    parameter int unsigned OUT_DIV = 384
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_left,
    input  logic [DATA_W-1:0] in_right,
    input  logic              n_wr,
    input  logic [N_W-1:0]    n_wr_data,
    output logic              out_strobe,
    output logic [DATA_W-1:0] out_left,
    output logic [DATA_W-1:0] out_right,
    output logic              underflow_flag,
    output logic              overflow_flag
);
    localparam int unsigned PAIR_W = 2 * DATA_W;

    logic              tick, strobe_pre;
    logic              buf_full, buf_empty, pop, uflow_pulse;
    logic [PAIR_W-1:0] buf_rdata;
    logic [N_W-1:0]    n_reg;
    logic [DATA_W-1:0] held_left, held_right;

    assign in_ready = !buf_full;

    hold_src44_timebase #(.UP_M(UP_M), .OUT_DIV(OUT_DIV)) u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .strobe_pre (strobe_pre)
    );

    hold_src44_fifo #(.W(PAIR_W), .DEPTH(DEPTH)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (in_valid),
        .wdata ({in_left, in_right}),
        .pop   (pop),
        .rdata (buf_rdata),
        .full  (buf_full),
        .empty (buf_empty)
    );

    hold_src44_ctrl #(.DATA_W(DATA_W), .N_W(N_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .n_val       (n_reg),
        .buf_empty   (buf_empty),
        .buf_left    (buf_rdata[PAIR_W-1:DATA_W]),
        .buf_right   (buf_rdata[DATA_W-1:0]),
        .pop         (pop),
        .uflow_pulse (uflow_pulse),
        .held_left   (held_left),
        .held_right  (held_right)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_reg          <= N_W'(DEFAULT_N);
            out_strobe     <= 1'b0;
            out_left       <= '0;
            out_right      <= '0;
            underflow_flag <= 1'b0;
            overflow_flag  <= 1'b0;
        end else begin
            if (n_wr) n_reg <= n_wr_data;
            out_strobe <= strobe_pre;
            if (strobe_pre) begin
                out_left  <= held_left;
                out_right <= held_right;
            end
            if (uflow_pulse)             underflow_flag <= 1'b1;
            if (in_valid && !in_ready)   overflow_flag  <= 1'b1;
        end
    end
endmodule

// File: rtl/hold_src44_chk.sv
module hold_src44_chk #(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned OUT_DIV = 384
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_strobe,
    input logic [DATA_W-1:0] out_left,
    input logic [DATA_W-1:0] out_right,
    input logic              underflow_flag,
    input logic              overflow_flag
);
    localparam int unsigned GW = $clog2(OUT_DIV) + 1;

    logic [GW-1:0] gap;
    logic          seen;
    logic          armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap   <= '0;
            seen  <= 1'b0;
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
            if (out_strobe) begin
                gap  <= '0;
                seen <= 1'b1;
            end else if (gap != {GW{1'b1}}) begin
                gap <= gap + 1'b1;
            end
        end
    end

    // R1
    strobe_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_strobe && seen) |-> (gap == GW'(OUT_DIV - 1)));

    // R1
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_strobe |=> !out_strobe);

    // R4
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !out_strobe) |-> ($stable(out_left) && $stable(out_right)));

    // R6
    overflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> overflow_flag);

    // R6
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_flag |=> overflow_flag);

    // R7
    underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_flag |=> underflow_flag);
endmodule

bind hold_src44 hold_src44_chk #(.DATA_W(DATA_W), .OUT_DIV(OUT_DIV)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .out_strobe     (out_strobe),
    .out_left       (out_left),
    .out_right      (out_right),
    .underflow_flag (underflow_flag),
    .overflow_flag  (overflow_flag)
);

// File: tb/tb_hold_src44.sv
`timescale 1ns/1ps
module tb_hold_src44;
    localparam int DW = 16;
    localparam int NW = 11;
    localparam logic [15:0] BAD = 16'hDEAD;
    localparam logic [15:0] ROFS = 16'h1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_left = '0, in_right = '0;
    logic          n_wr = 1'b0;
    logic [NW-1:0] n_wr_data = '0;
    logic          out_strobe;
    logic [DW-1:0] out_left, out_right;
    logic          underflow_flag, overflow_flag;

    int errors = 0;
    int checks = 0;

    hold_src44 dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_left(in_left), .in_right(in_right), .n_wr(n_wr), .n_wr_data(n_wr_data),
        .out_strobe(out_strobe), .out_left(out_left), .out_right(out_right),
        .underflow_flag(underflow_flag), .overflow_flag(overflow_flag)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // feeder: sole driver of the input port
    logic [DW-1:0] idx = 16'd1;
    bit feed_en = 0, inject_req = 0, inj_cur = 0;
    always @(negedge clk) begin
        if (in_valid && !inj_cur) idx = idx + 16'd1;
        inj_cur = 0;
        if (inject_req && !in_ready) begin
            in_valid = 1'b1; in_left = BAD; in_right = BAD + ROFS;
            inject_req = 0; inj_cur = 1;
        end else if (feed_en && in_ready) begin
            in_valid = 1'b1; in_left = idx; in_right = idx + ROFS;
        end else begin
            in_valid = 1'b0;
        end
    end

    // monitor
    int cyc = 0, last_strobe_cyc = -1, strobe_cnt = 0;
    logic [DW-1:0] last_l = '0, prev_l = '0;
    bit pair_en = 0, saw_bad = 0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (out_strobe) begin
                if (last_strobe_cyc >= 0)
                    check(cyc - last_strobe_cyc == 384, "R1 strobe spacing", cyc - last_strobe_cyc, 384);
                last_strobe_cyc = cyc;
                if (pair_en)
                    check(out_right == out_left + ROFS, "R4 pair", out_right, out_left + ROFS);
                if (out_left == BAD) saw_bad = 1;
                last_l = out_left;
                strobe_cnt++;
            end else if (out_left != prev_l) begin
                check(0, "R4 change without strobe", out_left, prev_l);
            end
        end
        prev_l = out_left;
    end

    task automatic wait_strobes(input int n);
        int target;
        target = strobe_cnt + n;
        while (strobe_cnt < target) @(negedge clk);
    endtask

    task automatic write_n(input int n);
        @(negedge clk); n_wr = 1'b1; n_wr_data = NW'(n);
        @(negedge clk); n_wr = 1'b0;
    endtask

    task automatic t_reset;
        check(out_strobe == 0, "R9 strobe", out_strobe, 0);
        check(underflow_flag == 0 && overflow_flag == 0, "R9 flags",
              {underflow_flag, overflow_flag}, 0);
        check(out_left == 0 && out_right == 0, "R9 outputs", out_left, 0);
        check(in_ready == 1, "R9 ready", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_strobe == 0 && out_left == 0 && in_ready == 1, "R9 after release", out_left, 0);
    endtask

    task automatic t_prime_idle;
        wait_strobes(3);
        check(underflow_flag == 0, "R10 no underflow while priming", underflow_flag, 0);
        check(last_l == 0, "R10 zero presented", last_l, 0);
    endtask

    task automatic t_default_rate;
        logic [DW-1:0] v0, d;
        feed_en = 1;
        wait_strobes(4);
        pair_en = 1;
        v0 = last_l;
        wait_strobes(147);
        d = last_l - v0;
        check(d >= 159 && d <= 161, "R8 default N=294 / R3 rate", d, 160);
        check(overflow_flag == 0, "R5 no overflow with ready-gated feed", overflow_flag, 0);
    endtask

    task automatic t_unity;
        logic [DW-1:0] p, d;
        write_n(320);
        wait_strobes(3);
        p = last_l;
        for (int i = 0; i < 8; i++) begin
            wait_strobes(1);
            d = last_l - p;
            check(d == 1, "R2/R5 one-to-one advance", d, 1);
            p = last_l;
        end
    endtask

    task automatic t_double;
        logic [DW-1:0] p, d;
        int sum;
        sum = 0;
        write_n(640);
        wait_strobes(3);
        p = last_l;
        for (int i = 0; i < 10; i++) begin
            wait_strobes(1);
            d = last_l - p;
            check(d <= 1, "R3 N=640 step", d, 1);
            sum += int'(d);
            p = last_l;
        end
        check(sum == 5, "R3 N=640 total", sum, 5);
    endtask

    task automatic t_slow;
        logic [DW-1:0] v0, d;
        write_n(1764);
        wait_strobes(3);
        v0 = last_l;
        wait_strobes(50);
        d = last_l - v0;
        check(d == 9 || d == 10, "R3 N=1764 rate", d, 9);
    endtask

    task automatic t_clamp;
        logic [DW-1:0] p, d;
        write_n(0);
        wait_strobes(3);
        p = last_l;
        for (int i = 0; i < 3; i++) begin
            wait_strobes(1);
            d = last_l - p;
            check(d == 320, "R8 N=0 acts as 1", d, 320);
            p = last_l;
        end
    endtask

    task automatic t_underflow;
        logic [DW-1:0] a;
        write_n(320);
        wait_strobes(3);
        check(underflow_flag == 0, "R7 no underflow while fed", underflow_flag, 0);
        feed_en = 0;
        wait_strobes(20);
        a = last_l;
        wait_strobes(1);
        check(underflow_flag == 1, "R7 flag set", underflow_flag, 1);
        check(last_l == a, "R7 repeat last pair", last_l, a);
        check(last_l == idx - 16'd1, "R5 last accepted pair presented", last_l, idx - 16'd1);
    endtask

    task automatic t_overflow;
        feed_en = 1;
        do @(negedge clk); while (in_ready);
        feed_en = 0;
        @(negedge clk);
        check(overflow_flag == 0, "R6 clear before drop", overflow_flag, 0);
        saw_bad = 0;
        inject_req = 1;
        repeat (4) @(negedge clk);
        check(overflow_flag == 1, "R6 flag set", overflow_flag, 1);
        wait_strobes(14);
        check(!saw_bad, "R6 dropped pair never presented", saw_bad, 0);
        check(last_l == idx - 16'd1, "R5/R6 order kept", last_l, idx - 16'd1);
        check(overflow_flag == 1 && underflow_flag == 1, "R6/R7 sticky",
              {overflow_flag, underflow_flag}, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_prime_idle();
        t_default_rate();
        t_unity();
        t_double();
        t_slow();
        t_clamp();
        t_underflow();
        t_overflow();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule